// File: doc/BRIEF.md
# DMA Interface Register Bank

This block is the register file that software sees on a 16-bit parallel DMA interface. It decodes four word addresses above a configurable base on a plain 16-bit register bus. The bus has read and write strobes and two byte enables. Behind those addresses are a transfer count, a transfer address, a control word and a data buffer. The control word shares its address with an error summary word. The block holds the output data and function lines it drives to the attached device. It captures the device's input data and hands the control settings, a start pulse and the captured data to a separate DMA cycle engine.

The register bus has no back-pressure. Every strobe is accepted in the cycle it is presented, and read data appears on the cycle after the read strobe. The device and engine pins are plain level or pulse signals with no handshake. A single address carries two views, picked by a select flag that only a control-word write can change. The input data is captured when software reads the buffer address or when the device raises either of its two cycle-request lines.

Top module: `dmaif_regbank`

## Requirements
- R1: Word offsets from BASE select the registers: +0 transfer count, +2 transfer address, +4 control/summary, +6 data buffer. Address bit 0 is ignored. Read data is registered and valid one cycle after `bus_rd`. A read of any other address returns 0, and a write to any other address changes nothing.
- R2: A write to +4 always lands in the control word, even while the summary view is selected.
- R3: A read of +4 returns the summary word when the select flag is 1 and the control word when it is 0. The flag is control-word bit 15 on write and summary-word bit 0 on read.
- R4: A write to +6 loads the output latch that drives `dev_out`. A read of +6 returns the input latch, never the output latch.
- R5: The input latch, visible on `eng_in_data`, loads `dev_in` on a read of +6 and in any cycle where `dev_cyc_req` is nonzero. It holds its value otherwise. The read returns the newly sampled value.
- R6: Bit 0 of the count and address registers reads `dev_wc0` and `dev_ba0` respectively. Writes to that bit have no effect.
- R7: Control word on read: [15] ERROR, [14] NXM, [13] `dev_attn`, [12] maint, [11:9] `dev_stat`, [8] cycle, [7] READY, [6] interrupt enable, [5:4] extended address (`eng_xba`), [3:1] function (`dev_func`), [0] reads 0.
- R8: Summary word: [15] ERROR, [14] NXM, [13] `dev_attn`, [12:8] = `eng_err[4:0]` flags, [7:1] zero, [0] select flag. The flags come from multi-cycle, AC-low, parity, burst timeout and no grant, in that order. NXM and these flags are sticky, set by `eng_nxm`/`eng_err` and cleared by a GO write.
- R9: Writing 1 to control bit 0 gives a one-cycle `eng_go` pulse on the next cycle and clears READY. `eng_done` sets READY, and GO wins when both occur in the same cycle.
- R10: ERROR is the OR of NXM, `dev_attn` and the five flags. `irq` pulses for one cycle when interrupt enable is 1 and either READY rises via `eng_done` or ERROR rises. With interrupt enable at 0 it stays low.
- R11: Byte enable 0 gates bits 7:0 and byte enable 1 gates bits 15:8 of every writable register. Disabled lanes and read-only bits keep their value.
- R12: Synchronous `rst` clears all registers, latches and the select flag, and sets READY. The control word then reads 0x0080 with device inputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register bus byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 2 | Byte enables (bit 1 = high byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| dev_in | input | 16 | Device input data |
| dev_out | output | 16 | Device output data latch |
| dev_cyc_req | input | 2 | Device cycle-request lines |
| dev_wc0 | input | 1 | Count register bit 0 from device |
| dev_ba0 | input | 1 | Address register bit 0 from device |
| dev_stat | input | 3 | Device status lines |
| dev_attn | input | 1 | Device attention line |
| dev_func | output | 3 | Function lines to device |
| eng_go | output | 1 | Start pulse to DMA engine |
| eng_done | input | 1 | Transfer finished pulse |
| eng_nxm | input | 1 | Non-existent memory error pulse |
| eng_err | input | 5 | Error flag set pulses |
| eng_wc | output | 16 | Transfer count value |
| eng_ba | output | 16 | Transfer address value |
| eng_xba | output | 2 | Extended address bits |
| eng_in_data | output | 16 | Input latch value |
| irq | output | 1 | Interrupt request pulse |

## Verification
A corrupted select flag shows on the very next read of +4, as the wrong view with bit 0 of the summary word disagreeing. A stuck or lost READY shows in the control word one read after a GO write or an `eng_done` pulse, and in a missing or extra `irq` pulse one cycle after the event. A wrong input-latch load shows on `eng_in_data` on the cycle after the spurious or missed capture. A lane-gating fault shows as a changed neighbouring byte on the next read or on `dev_out`.

// File: rtl/dmaif_pkg.sv
package dmaif_pkg;
  localparam int DW = 16;
  localparam int NBYTE = DW / 8;

  typedef enum logic [1:0] {
    SEL_WC = 2'd0,
    SEL_BA = 2'd1,
    SEL_CS = 2'd2,
    SEL_DB = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     hit;
    reg_sel_e sel;
  } dec_t;

  localparam int CS_SELBIT = 15;
  localparam int CS_MAINT  = 12;
  localparam int CS_CYCLE  = 8;
  localparam int CS_IE     = 6;
  localparam int CS_GO     = 0;
  localparam int NERR      = 5;
endpackage

// File: rtl/dmaif_decode.sv
module dmaif_decode
  import dmaif_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int unsigned BASE = 'hFF08
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);

  logic unused_bits;
  assign unused_bits = addr[0];

  assign dec.hit = (addr[ADDR_W-1:3] == BASE_V[ADDR_W-1:3]);
  assign dec.sel = reg_sel_e'(addr[2:1]);
endmodule

// File: rtl/dmaif_wordreg.sv
module dmaif_wordreg #(
  parameter int W      = 16,
  parameter bit RO_LSB = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [W/8-1:0] be,
  input  logic [W-1:0]   wd,
  input  logic           lsb_pin,
  output logic [W-1:0]   q
);
  localparam int NB = W / 8;
  logic [W-1:0] r;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst)               lane_q <= '0;
      else if (we && be[b])  lane_q <= wd[b*8 +: 8];
    end
    assign r[b*8 +: 8] = lane_q;
  end

  logic [1:0] unused_bits;
  assign unused_bits = {r[0], lsb_pin};

  if (RO_LSB) begin : g_ro
    assign q = {r[W-1:1], lsb_pin};
  end else begin : g_rw
    assign q = r;
  end
endmodule

// File: rtl/dmaif_ctrl.sv
module dmaif_ctrl
  import dmaif_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_we,
  input  logic [1:0]      be,
  input  logic [DW-1:0]   wd,
  input  logic [2:0]      dev_stat,
  input  logic            dev_attn,
  input  logic            nxm_set,
  input  logic [NERR-1:0] err_set,
  input  logic            eng_done,
  output logic [DW-1:0]   csr_rd,
  output logic [DW-1:0]   eir_rd,
  output logic            regsel,
  output logic            ready,
  output logic            ie,
  output logic            eng_go,
  output logic [2:0]      func,
  output logic [1:0]      xba,
  output logic            irq
);
  logic            maint_q, cycle_q, nxm_q, err_prev_q;
  logic [NERR-1:0] errf_q;
  logic            go_wr, error;

  assign go_wr = cs_we && be[0] && wd[CS_GO];
  assign error = nxm_q || dev_attn || (|errf_q);

  logic [4:0] unused_bits;
  assign unused_bits = {wd[14], wd[13], wd[11:9] == 3'b000 ? 1'b0 : 1'b1, wd[7], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      regsel  <= 1'b0;
      maint_q <= 1'b0;
      cycle_q <= 1'b0;
    end else if (cs_we && be[1]) begin
      regsel  <= wd[CS_SELBIT];
      maint_q <= wd[CS_MAINT];
      cycle_q <= wd[CS_CYCLE];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie   <= 1'b0;
      xba  <= '0;
      func <= '0;
    end else if (cs_we && be[0]) begin
      ie   <= wd[CS_IE];
      xba  <= wd[5:4];
      func <= wd[3:1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready      <= 1'b1;
      eng_go     <= 1'b0;
      nxm_q      <= 1'b0;
      errf_q     <= '0;
      err_prev_q <= 1'b0;
      irq        <= 1'b0;
    end else begin
      eng_go     <= go_wr;
      err_prev_q <= error;
      irq        <= ie && ((eng_done && !ready && !go_wr) || (error && !err_prev_q));
      if (go_wr)         ready <= 1'b0;
      else if (eng_done) ready <= 1'b1;
      if (go_wr) begin
        nxm_q  <= 1'b0;
        errf_q <= '0;
      end else begin
        nxm_q  <= nxm_q | nxm_set;
        errf_q <= errf_q | err_set;
      end
    end
  end

  assign csr_rd = {error, nxm_q, dev_attn, maint_q, dev_stat, cycle_q,
                   ready, ie, xba, func, 1'b0};
  assign eir_rd = {error, nxm_q, dev_attn, errf_q, 7'b0, regsel};
endmodule

// File: rtl/dmaif_regbank.sv
module dmaif_regbank
  import dmaif_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int unsigned BASE = 'hFF08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_be,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic [15:0]       dev_in,
  output logic [15:0]       dev_out,
  input  logic [1:0]        dev_cyc_req,
  input  logic              dev_wc0,
  input  logic              dev_ba0,
  input  logic [2:0]        dev_stat,
  input  logic              dev_attn,
  output logic [2:0]        dev_func,
  output logic              eng_go,
  input  logic              eng_done,
  input  logic              eng_nxm,
  input  logic [4:0]        eng_err,
  output logic [15:0]       eng_wc,
  output logic [15:0]       eng_ba,
  output logic [1:0]        eng_xba,
  output logic [15:0]       eng_in_data,
  output logic              irq
);
  dec_t          dec;
  logic          wr_wc, wr_ba, wr_cs, wr_db, rd_db;
  logic [DW-1:0] csr_rd, eir_rd, in_q;
  logic          regsel, ready, ie;

  dmaif_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr(bus_addr), .dec(dec)
  );

  assign wr_wc = bus_wr && dec.hit && (dec.sel == SEL_WC);
  assign wr_ba = bus_wr && dec.hit && (dec.sel == SEL_BA);
  assign wr_cs = bus_wr && dec.hit && (dec.sel == SEL_CS);
  assign wr_db = bus_wr && dec.hit && (dec.sel == SEL_DB);
  assign rd_db = bus_rd && dec.hit && (dec.sel == SEL_DB);

  dmaif_wordreg #(.W(DW), .RO_LSB(1'b1)) u_wc (
    .clk(clk), .rst(rst), .we(wr_wc), .be(bus_be), .wd(bus_wdata),
    .lsb_pin(dev_wc0), .q(eng_wc)
  );

  dmaif_wordreg #(.W(DW), .RO_LSB(1'b1)) u_ba (
    .clk(clk), .rst(rst), .we(wr_ba), .be(bus_be), .wd(bus_wdata),
    .lsb_pin(dev_ba0), .q(eng_ba)
  );

  dmaif_wordreg #(.W(DW), .RO_LSB(1'b0)) u_out (
    .clk(clk), .rst(rst), .we(wr_db), .be(bus_be), .wd(bus_wdata),
    .lsb_pin(1'b0), .q(dev_out)
  );

  dmaif_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cs_we(wr_cs), .be(bus_be), .wd(bus_wdata),
    .dev_stat(dev_stat), .dev_attn(dev_attn), .nxm_set(eng_nxm),
    .err_set(eng_err), .eng_done(eng_done), .csr_rd(csr_rd),
    .eir_rd(eir_rd), .regsel(regsel), .ready(ready), .ie(ie),
    .eng_go(eng_go), .func(dev_func), .xba(eng_xba), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst)                         in_q <= '0;
    else if (rd_db || |dev_cyc_req)  in_q <= dev_in;
  end
  assign eng_in_data = in_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (!dec.hit) bus_rdata <= '0;
      else begin
        unique case (dec.sel)
          SEL_WC: bus_rdata <= eng_wc;
          SEL_BA: bus_rdata <= eng_ba;
          SEL_CS: bus_rdata <= regsel ? eir_rd : csr_rd;
          SEL_DB: bus_rdata <= dev_in;
        endcase
      end
    end
  end
endmodule

// File: rtl/dmaif_regbank_chk.sv
module dmaif_regbank_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [1:0]  cyc_req,
  input logic [15:0] dev_out,
  input logic [15:0] in_q,
  input logic        ready,
  input logic        ie,
  input logic        eng_go,
  input logic        irq
);
  a_r9_go_single: assert property (@(posedge clk) disable iff (rst)
    eng_go |=> !eng_go);

  a_r9_go_clears_ready: assert property (@(posedge clk) disable iff (rst)
    eng_go |-> !ready);

  a_r4_out_holds: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(dev_out));

  a_r5_in_holds: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd && cyc_req == 2'b00) |=> $stable(in_q));

  a_r10_irq_needs_ie: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ie));

  a_r10_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq || $past(ie));

  a_r12_reset_state: assert property (@(posedge clk)
    rst |=> (ready && !ie && !eng_go && !irq));
endmodule

bind dmaif_regbank dmaif_regbank_chk u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .cyc_req(dev_cyc_req), .dev_out(dev_out), .in_q(in_q),
  .ready(ready), .ie(ie), .eng_go(eng_go), .irq(irq)
);

// File: tb/dmaif_regbank_bench.sv
module dmaif_regbank_bench;
  localparam logic [15:0] BASE = 16'hFF08;
  localparam logic [15:0] O_WC = 16'd0, O_BA = 16'd2, O_CS = 16'd4, O_DB = 16'd6;

  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_be = 2'b11, dev_cyc_req = 2'b00, eng_xba;
  logic [15:0] dev_in = '0, dev_out, eng_wc, eng_ba, eng_in_data;
  logic dev_wc0 = 0, dev_ba0 = 0, dev_attn = 0, eng_done = 0, eng_nxm = 0;
  logic eng_go, irq;
  logic [2:0] dev_stat = '0, dev_func;
  logic [4:0] eng_err = '0;
  int total = 0, bad = 0, irq_cnt = 0, go_cnt = 0;

  always #10 clk = ~clk;

  dmaif_regbank u_dmaif_regbank (.*);

  always @(posedge clk) begin
    if (!rst && irq)    irq_cnt <= irq_cnt + 1;
    if (!rst && eng_go) go_cnt  <= go_cnt + 1;
  end

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [15:0] off, logic [1:0] be, logic [15:0] d);
    @(negedge clk);
    bus_addr = BASE + off; bus_be = be; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [15:0] off, output logic [15:0] d);
    @(negedge clk);
    bus_addr = BASE + off; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(O_CS, d);
    chk("R12 csr after reset", d, 16'h0080);
    chk("R12 dev_out after reset", dev_out, 16'h0000);
  endtask

  task automatic t_count_addr();
    logic [15:0] d;
    wr(O_WC, 2'b11, 16'hFFFF);
    rd(O_WC, d); chk("R6 wc bit0 from pin low", d, 16'hFFFE);
    dev_wc0 = 1;
    rd(O_WC, d); chk("R6 wc bit0 from pin high", d, 16'hFFFF);
    wr(O_WC, 2'b01, 16'h1234);
    rd(O_WC, d); chk("R11 wc low byte only", d, 16'hFF35);
    wr(O_BA, 2'b11, 16'hABCD);
    rd(O_BA, d); chk("R1 ba offset +2", d, 16'hABCC);
    chk("R1 eng_wc unchanged by ba write", eng_wc, 16'hFF35);
  endtask

  task automatic t_select();
    logic [15:0] d;
    wr(O_CS, 2'b11, 16'h8000);
    rd(O_CS, d); chk("R3 summary view when select=1", d, 16'h0001);
    wr(O_CS, 2'b11, 16'h0046);
    rd(O_CS, d); chk("R2 write lands in control word", d, 16'h00C6);
    chk("R7 function lines", {13'b0, dev_func}, 16'h0003);
    wr(O_CS, 2'b10, 16'h1100);
    dev_stat = 3'b101;
    rd(O_CS, d); chk("R11 R7 high byte only, status lines", d, 16'h1BC6);
    dev_stat = 3'b000;
    wr(O_CS, 2'b10, 16'h0000);
    rd(O_CS, d); chk("R11 low byte kept", d, 16'h00C6);
  endtask

  task automatic t_go();
    logic [15:0] d;
    int g0, i0;
    g0 = go_cnt; i0 = irq_cnt;
    wr(O_CS, 2'b01, 16'h0047);
    @(negedge clk);
    chk("R9 one go pulse", 16'(go_cnt - g0), 16'd1);
    rd(O_CS, d); chk("R9 ready cleared, go reads 0", d, 16'h0046);
    pulse_done();
    chk("R10 irq on ready rise", 16'(irq_cnt - i0), 16'd1);
    rd(O_CS, d); chk("R9 done sets ready", d, 16'h00C6);
    i0 = irq_cnt;
    wr(O_CS, 2'b01, 16'h0007);
    pulse_done();
    chk("R10 no irq with ie clear", 16'(irq_cnt - i0), 16'd0);
    wr(O_CS, 2'b01, 16'h0046);
  endtask

  task automatic t_errors();
    logic [15:0] d;
    int i0;
    i0 = irq_cnt;
    @(negedge clk); eng_err = 5'b00100;
    @(negedge clk); eng_err = 5'b00000;
    @(negedge clk); @(negedge clk);
    chk("R10 irq on error rise", 16'(irq_cnt - i0), 16'd1);
    rd(O_CS, d); chk("R10 error bit in control word", d, 16'h80C6);
    wr(O_CS, 2'b10, 16'h8000);
    rd(O_CS, d); chk("R8 parity flag in summary", d, 16'h8401);
    @(negedge clk); eng_nxm = 1;
    @(negedge clk); eng_nxm = 0;
    rd(O_CS, d); chk("R8 nxm sticky", d, 16'hC401);
    dev_attn = 1;
    rd(O_CS, d); chk("R8 attn live", d, 16'hE401);
    dev_attn = 0;
    wr(O_CS, 2'b11, 16'h0047);
    pulse_done();
    rd(O_CS, d); chk("R8 go clears flags", d, 16'h00C6);
  endtask

  task automatic t_buffer();
    logic [15:0] d;
    wr(O_DB, 2'b11, 16'h5A3C);
    chk("R4 output latch", dev_out, 16'h5A3C);
    wr(O_DB, 2'b10, 16'hFF00);
    chk("R11 output high byte", dev_out, 16'hFF3C);
    dev_in = 16'h1357;
    rd(O_DB, d);
    chk("R4 read returns input", d, 16'h1357);
    chk("R5 read samples input", eng_in_data, 16'h1357);
    chk("R4 output untouched by read", dev_out, 16'hFF3C);
    dev_in = 16'h2468;
    @(negedge clk); @(negedge clk);
    chk("R5 latch holds", eng_in_data, 16'h1357);
    dev_cyc_req = 2'b10;
    @(negedge clk); dev_cyc_req = 2'b00;
    chk("R5 cycle request samples", eng_in_data, 16'h2468);
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    rd(16'd8, d); chk("R1 unmapped read", d, 16'h0000);
    wr(16'd8, 2'b11, 16'h0000);
    rd(O_WC, d); chk("R1 unmapped write ignored", d, 16'hFF35);
  endtask

  task automatic t_reset_again();
    logic [15:0] d;
    wr(O_CS, 2'b11, 16'h8040);
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    rd(O_CS, d); chk("R12 select cleared by reset", d, 16'h0080);
    chk("R12 output latch cleared", dev_out, 16'h0000);
    chk("R12 input latch cleared", eng_in_data, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_count_addr();
    t_select();
    t_go();
    t_errors();
    t_buffer();
    t_unmapped();
    t_reset_again();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule